// File: doc/BRIEF.md
# Branch Target Buffer Next Fetch Address Unit

This block sits in the fetch stage and, in the same cycle as the fetch program counter arrives, decides where fetch goes next. A direct-mapped table of branch targets is looked up with the fetch address. A valid entry with a matching tag counts as proof that the fetched instruction is a branch, with no decode step. Such an entry holds the target that branch jumped to the last time it was taken. If that same branch is also predicted taken, fetch is redirected to the stored target. In every other case fetch moves on to the next sequential instruction.

The direction comes from one of two sources. In external mode an outside direction predictor drives the taken input. In always-taken mode every hit is treated as taken. The execute stage trains the table through a resolve port. A resolved taken branch writes or overwrites the entry at its index. A resolved not-taken branch leaves the table as it is.

Top module: `btb_fetch_predictor`

## Requirements
- R1: After reset every entry is invalid, so every fetch gives hit_o=0, pred_taken_o=0 and next_pc_o = fetch_pc_i + 4.
- R2: The entry index is fetch_pc_i[7:2] and the tag is fetch_pc_i[31:8]. A hit needs a valid entry whose stored tag equals the tag of the fetch address. An address with the same index but a different tag misses.
- R3: When hit_o is 1 and the branch is predicted taken, next_pc_o equals the stored target and pred_taken_o is 1.
- R4: In external mode (dir_mode_i=0), a hit with taken_pred_i=0 gives hit_o=1, pred_taken_o=0 and next_pc_o = fetch_pc_i + 4.
- R5: In always-taken mode (dir_mode_i=1), every hit is predicted taken, whatever the value of taken_pred_i.
- R6: On a miss, next_pc_o = fetch_pc_i + 4 and pred_taken_o=0, for any values of taken_pred_i and dir_mode_i.
- R7: A resolve with upd_valid_i=1 and upd_taken_i=1 writes the tag and target of upd_pc_i into its index. This replaces an older target for the same branch, or an entry held by another branch that maps to the same index.
- R8: A resolve with upd_taken_i=0 leaves the table unchanged. Lookups afterwards give the same results as before it.
- R9: A write becomes visible to lookups starting from the cycle after its resolve cycle. A lookup in the same cycle as the write sees the old contents.
- R10: hit_o, pred_taken_o and next_pc_o follow fetch_pc_i combinationally, in the same cycle.
- R11: The sequential address wraps modulo 2^32, so a miss at 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Current fetch address |
| taken_pred_i | input | 1 | Taken prediction from an external direction predictor |
| dir_mode_i | input | 1 | 0: use taken_pred_i, 1: always predict taken on a hit |
| upd_valid_i | input | 1 | Resolve port carries a resolved branch |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |
| upd_taken_i | input | 1 | The resolved branch was taken |
| next_pc_o | output | 32 | Next fetch address |
| hit_o | output | 1 | Fetched instruction found in the table (treated as a branch) |
| pred_taken_o | output | 1 | Redirect to the stored target predicted |

## Verification
The hardest cases to reach involve two branches that share an index, and a write landing in the same cycle as a lookup of that index. The stimulus trains a branch, then sends a lookup of the same index with a different tag. Next it resolves the alias as taken, which evicts the first branch. It also sends a lookup together with a write to the same entry, and checks that the old contents show in that cycle and the new ones in the cycle after. A bench-side model of the table, updated one cycle after each resolve, gives the expected value of every lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic {
    DIR_EXTERNAL     = 1'b0,
    DIR_ALWAYS_TAKEN = 1'b1
  } dir_mode_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = pc_i[OFF_W +: IDX_W];
  assign tag_o = pc_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  look_idx_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic we;
    logic v_q;
    assign we = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (we)  v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (we) begin
        tag_q[e] <= wr_tag_i;
        tgt_q[e] <= wr_tgt_i;
      end
    end

    assign vld_q[e] = v_q;
    assign match[e] = v_q && (look_idx_i == IDX_W'(e)) && (tag_q[e] == look_tag_i);
  end

  always_comb begin
    tgt_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) tgt_o = tgt_o | tgt_q[e];
    end
  end

  assign hit_o = |match;

  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)) else $error("multiple entries match"); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx_i)] && tgt_q[$past(wr_idx_i)] == $past(wr_tgt_i)
                 && tag_q[$past(wr_idx_i)] == $past(wr_tag_i))) else $error("write lost"); // R7
  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(vld_q)) else $error("valid changed without write"); // R8
endmodule

// File: rtl/btb_next_sel.sv
module btb_next_sel
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              taken_pred_i,
  input  dir_mode_e         mode_i,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic              dir_taken;
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc_i + ADDR_W'(INST_BYTES);

  always_comb begin
    unique case (mode_i)
      DIR_ALWAYS_TAKEN: dir_taken = 1'b1;
      default:          dir_taken = taken_pred_i;
    endcase
  end

  assign pred_taken_o = hit_i && dir_taken;
  assign next_pc_o    = pred_taken_o ? tgt_i : seq_pc;

  AST_REDIRECT_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> next_pc_o == tgt_i) else $error("redirect target wrong"); // R3
  AST_NT_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_i == DIR_EXTERNAL && !taken_pred_i) |-> (!pred_taken_o && next_pc_o == seq_pc))
    else $error("not-taken hit redirected"); // R4
endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int INST_BYTES = 4,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int OFF_W     = $clog2(INST_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              taken_pred_i,
  input  logic              dir_mode_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_taken_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              hit_o,
  output logic              pred_taken_o
);
  logic [IDX_W-1:0]  look_idx, wr_idx;
  logic [TAG_W-1:0]  look_tag, wr_tag;
  logic [ADDR_W-1:0] stored_tgt;
  logic              wr_en;
  dir_mode_e         mode;

  assign mode  = dir_mode_e'(dir_mode_i);
  assign wr_en = upd_valid_i && upd_taken_i;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_look_split (
    .pc_i(fetch_pc_i), .idx_o(look_idx), .tag_o(look_tag));

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_upd_split (
    .pc_i(upd_pc_i), .idx_o(wr_idx), .tag_o(wr_tag));

  btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .look_idx_i(look_idx), .look_tag_i(look_tag),
    .hit_o, .tgt_o(stored_tgt),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_tgt_i(upd_target_i));

  btb_next_sel #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_sel (
    .clk_i, .rst_ni,
    .pc_i(fetch_pc_i), .hit_i(hit_o), .tgt_i(stored_tgt),
    .taken_pred_i, .mode_i(mode),
    .pred_taken_o, .next_pc_o);

  AST_MISS_FALLTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + ADDR_W'(INST_BYTES)))
    else $error("miss did not fall through"); // R6
  AST_ALWAYS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_mode_i && hit_o) |-> pred_taken_o) else $error("always-taken mode ignored"); // R5
endmodule

// File: tb/btb_fetch_predictor_tb.sv
module btb_fetch_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_tgt = '0;
  logic        tp = 1'b0, mode = 1'b0, uv = 1'b0, ut = 1'b0;
  logic [31:0] next_pc;
  logic        hit, pt;

  always #5 clk = ~clk;

  btb_fetch_predictor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc), .taken_pred_i(tp),
    .dir_mode_i(mode), .upd_valid_i(uv), .upd_pc_i(upd_pc), .upd_target_i(upd_tgt),
    .upd_taken_i(ut), .next_pc_o(next_pc), .hit_o(hit), .pred_taken_o(pt));

  typedef struct {
    logic [31:0] nxt;
    logic        hit;
    logic        pt;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          total = 0, bad = 0;
  bit          done = 1'b0;
  logic        m_vld [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];

  task automatic step(input logic [31:0] pc, input logic tpi, input logic md,
                      input logic v, input logic [31:0] upc, input logic [31:0] utg,
                      input logic tk, input string req);
    exp_t e;
    int   ix;
    @(negedge clk);
    fetch_pc = pc; tp = tpi; mode = md; uv = v; upd_pc = upc; upd_tgt = utg; ut = tk;
    ix = int'(pc[7:2]);
    e.hit = m_vld[ix] && (m_tag[ix] == pc[31:8]);
    e.pt  = e.hit && (md || tpi);
    e.nxt = e.pt ? m_tgt[ix] : pc + 32'd4;
    e.req = req;
    sb_q.push_back(e);
    if (v && tk) begin
      m_vld[int'(upc[7:2])] = 1'b1;
      m_tag[int'(upc[7:2])] = upc[31:8];
      m_tgt[int'(upc[7:2])] = utg;
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic tpi, input logic md, input string req);
    step(pc, tpi, md, 1'b0, 32'h0, 32'h0, 1'b0, req);
  endtask

  task automatic train(input logic [31:0] upc, input logic [31:0] utg, input logic tk, input string req);
    step(32'h0000_0040, 1'b0, 1'b0, 1'b1, upc, utg, tk, req);
  endtask

  // monitor: compare away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (next_pc !== e.nxt || hit !== e.hit || pt !== e.pt) begin
          bad++;
          $display("FAIL %s: got next=%h hit=%b pt=%b exp next=%h hit=%b pt=%b",
                   e.req, next_pc, hit, pt, e.nxt, e.hit, e.pt);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
    look(32'h0000_0100, 1'b1, 1'b1, "R1");          // in reset
    @(negedge clk); rst_n = 1'b1;
    look(32'h0000_1000, 1'b1, 1'b0, "R1");
    look(32'h0000_2344, 1'b1, 1'b1, "R1");
    // write and concurrent lookup of the same entry: old contents this cycle
    step(32'h0000_1000, 1'b1, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_2000, 1'b1, "R9");
    look(32'h0000_1000, 1'b1, 1'b0, "R9 R3");
    look(32'h0000_1000, 1'b0, 1'b0, "R4");
    look(32'h0000_1000, 1'b0, 1'b1, "R5");
    look(32'h0000_1100, 1'b1, 1'b1, "R2 R6");       // same index, other tag
    look(32'h0000_1004, 1'b1, 1'b1, "R2 R6");       // neighbour index
    train(32'h0000_1000, 32'h0000_3000, 1'b0, "R8");
    look(32'h0000_1000, 1'b1, 1'b0, "R8");
    train(32'h0000_1000, 32'h0000_3000, 1'b1, "R7");
    look(32'h0000_1000, 1'b1, 1'b0, "R7");
    train(32'h0000_1100, 32'h0000_0800, 1'b1, "R7");
    look(32'h0000_1000, 1'b1, 1'b1, "R7");          // evicted
    look(32'h0000_1100, 1'b0, 1'b1, "R7");
    look(32'hFFFF_FFFC, 1'b1, 1'b1, "R11");
    // fill table with a pattern, then check same-cycle lookups across it
    for (int i = 0; i < 64; i++)
      train(32'hA000_0000 + 32'(i * 4), 32'h0050_0000 + 32'(i * 16), 1'b1, "R7");
    for (int i = 0; i < 64; i++)
      look(32'hA000_0000 + 32'(i * 4), i[0], i[1], "R10");
    for (int i = 0; i < 8; i++)
      look(32'hB000_0000 + 32'(i * 4), 1'b1, 1'b1, "R2");
    look(32'h0000_0000, 1'b0, 1'b0, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule